// File: doc/BRIEF.md
# Operand Bypass Select Unit

This block chooses, for an instruction sitting at the start of the execute stage of a five-stage load/store pipeline, where each of its operands should come from. Each of the two ALU operands can come from the register file, from the result held one stage ahead (execute/memory boundary), or from the value held two stages ahead (memory/writeback boundary). A third select controls the data a store writes to memory. When the store's data register is written by the instruction just ahead of it, that select takes the writeback-stage value instead. The writeback-stage value can be either an ALU result or loaded data.

The unit is purely combinational. It compares register numbers and write-enable flags carried down the pipeline. The destination numbers it sees are the ones already chosen by the destination multiplexer. A destination of register zero never produces a bypass, so a read of register zero always returns the register file's zero. The operand multiplexers, the register file and any stall logic sit outside this block.

Top module: `bypass_select`

## Requirements
- R1: With no matching destination, both operand selects are 2'b00 (register file) and the store select is 0.
- R2: The A select is 2'b10 when the execute/memory stage writes a nonzero register equal to the first source register.
- R3: The B select is 2'b10 when the execute/memory stage writes a nonzero register equal to the second source register.
- R4: The A select is 2'b01 when the memory/writeback stage writes a nonzero register equal to the first source register and R2 does not apply.
- R5: The B select is 2'b01 when the memory/writeback stage writes a nonzero register equal to the second source register and R3 does not apply.
- R6: When both later stages write the same source register, the execute/memory value (2'b10) wins, because it is the newer value.
- R7: The store select is 1 when the memory/writeback stage writes a nonzero register equal to the store-data register held at the execute/memory boundary.
- R8: A destination of register zero never causes any select to leave its register-file setting, even with its write flag set.
- R9: A stage whose write flag is clear never causes a bypass from that stage, even when its register number matches.
- R10: The operand selects never take the value 2'b11, and every select follows its inputs within the same cycle with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_src_a | input | 5 | First source register number at the start of execute |
| ex_src_b | input | 5 | Second source register number at the start of execute |
| mem_dst | input | 5 | Destination register number of the instruction in the memory stage |
| mem_wr | input | 1 | Register-write flag of the instruction in the memory stage |
| mem_store_src | input | 5 | Store-data register number of the instruction in the memory stage |
| wb_dst | input | 5 | Destination register number of the instruction in writeback |
| wb_wr | input | 1 | Register-write flag of the instruction in writeback |
| sel_a | output | 2 | Source select for ALU operand A: 00 file, 10 memory stage, 01 writeback |
| sel_b | output | 2 | Source select for ALU operand B, same encoding |
| sel_store | output | 1 | 1 routes the writeback value into the store-data input |

## Verification
The hardest case to reach is the one where every comparison is live at once. Both later stages write the same nonzero register, both ALU operands name it, and the store-data register also names it. Then priority, the zero exclusion and the store path all act in the same cycle. The stimulus gets there in two ways. Directed vectors set this case up exactly. A long run of pseudo-random vectors draws every register number from a pool of only four values, including zero. That keeps full and partial overlaps, and matches on register zero, frequent.

// File: rtl/bypass_select.sv
module bypass_select #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] ex_src_a,
  input  logic [REG_W-1:0] ex_src_b,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr,
  input  logic [REG_W-1:0] mem_store_src,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wr,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b,
  output logic             sel_store
);

  localparam logic [1:0] SEL_FILE = 2'b00;
  localparam logic [1:0] SEL_WB   = 2'b01;
  localparam logic [1:0] SEL_MEM  = 2'b10;
  localparam int         NSRC     = 2;

  logic             mem_live, wb_live;
  logic [REG_W-1:0] src     [NSRC];
  logic [1:0]       sel_op  [NSRC];

  // a destination of register zero is never a bypass source
  assign mem_live = mem_wr && (mem_dst != '0);
  assign wb_live  = wb_wr  && (wb_dst  != '0);

  assign src[0] = ex_src_a;
  assign src[1] = ex_src_b;

  for (genvar i = 0; i < NSRC; i++) begin : g_op
    assign sel_op[i] = (mem_live && mem_dst == src[i]) ? SEL_MEM :
                       (wb_live  && wb_dst  == src[i]) ? SEL_WB  : SEL_FILE;

    always_comb begin
      assert_no_code11_R10: assert (sel_op[i] != 2'b11)
        else $error("operand select %0d holds reserved code", i);
      assert_zero_reg_R8: assert (src[i] != '0 || sel_op[i] == SEL_FILE)
        else $error("register zero bypassed on operand %0d", i);
      assert_newer_wins_R6: assert (!(mem_wr && wb_wr && mem_dst == wb_dst &&
                                      mem_dst == src[i] && src[i] != '0) ||
                                    sel_op[i] == SEL_MEM)
        else $error("older stage won on operand %0d", i);
      assert_flag_needed_R9: assert ((sel_op[i] != SEL_MEM || mem_wr) &&
                                     (sel_op[i] != SEL_WB  || wb_wr))
        else $error("bypass from a non-writing stage on operand %0d", i);
    end
  end

  assign sel_a     = sel_op[0];
  assign sel_b     = sel_op[1];
  assign sel_store = wb_live && (wb_dst == mem_store_src);

  always_comb begin
    assert_store_path_R7: assert (!sel_store ||
                                  (wb_wr && wb_dst == mem_store_src && mem_store_src != '0))
      else $error("store select set without a writeback match");
  end

endmodule

// File: tb/bypass_select_tb.sv
module bypass_select_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [4:0] ex_src_a, ex_src_b, mem_dst, mem_store_src, wb_dst;
  logic       mem_wr, wb_wr;
  logic [1:0] sel_a, sel_b;
  logic       sel_store;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  bypass_select u_dut (
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
    .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_store_src(mem_store_src),
    .wb_dst(wb_dst), .wb_wr(wb_wr),
    .sel_a(sel_a), .sel_b(sel_b), .sel_store(sel_store)
  );

  function automatic int model_op(int s);
    if (mem_wr && mem_dst != 0 && int'(mem_dst) == s) return 2;
    if (wb_wr && wb_dst != 0 && int'(wb_dst) == s) return 1;
    return 0;
  endfunction

  task automatic chk(string req, logic [4:0] exp);
    logic [4:0] got;
    got = {sel_a, sel_b, sel_store};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got a=%b b=%b st=%b expected a=%b b=%b st=%b",
               req, got[4:3], got[2:1], got[0], exp[4:3], exp[2:1], exp[0]);
    end
  endtask

  task automatic drive(logic [4:0] a, logic [4:0] b, logic [4:0] md, logic mw,
                       logic [4:0] ms, logic [4:0] wd, logic ww);
    @(posedge clk);
    ex_src_a = a; ex_src_b = b; mem_dst = md; mem_wr = mw;
    mem_store_src = ms; wb_dst = wd; wb_wr = ww;
    @(negedge clk);
  endtask

  initial begin
    ex_src_a = '0; ex_src_b = '0; mem_dst = '0; mem_store_src = '0;
    wb_dst = '0; mem_wr = 1'b0; wb_wr = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle", 5'b00_00_0);

    drive(5'd6, 5'd8, 5'd11, 1'b1, 5'd13, 5'd14, 1'b1);
    chk("R1 no match", 5'b00_00_0);
    drive(5'd3, 5'd4, 5'd3, 1'b1, 5'd20, 5'd21, 1'b0);
    chk("R2", 5'b10_00_0);
    drive(5'd3, 5'd4, 5'd4, 1'b1, 5'd20, 5'd21, 1'b0);
    chk("R3", 5'b00_10_0);
    drive(5'd7, 5'd4, 5'd1, 1'b1, 5'd20, 5'd7, 1'b1);
    chk("R4", 5'b01_00_0);
    drive(5'd2, 5'd7, 5'd1, 1'b1, 5'd20, 5'd7, 1'b1);
    chk("R5", 5'b00_01_0);
    drive(5'd9, 5'd9, 5'd9, 1'b1, 5'd9, 5'd9, 1'b1);
    chk("R6 both operands and store", 5'b10_10_1);
    drive(5'd9, 5'd5, 5'd5, 1'b1, 5'd1, 5'd9, 1'b1);
    chk("R6 split", 5'b01_10_0);
    drive(5'd1, 5'd2, 5'd3, 1'b0, 5'd12, 5'd12, 1'b1);
    chk("R7", 5'b00_00_1);
    drive(5'd1, 5'd2, 5'd3, 1'b0, 5'd12, 5'd12, 1'b0);
    chk("R7 flag clear", 5'b00_00_0);
    drive(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 5'd0, 1'b1);
    chk("R8 all zero", 5'b00_00_0);
    drive(5'd0, 5'd5, 5'd0, 1'b1, 5'd0, 5'd5, 1'b1);
    chk("R8 mem zero", 5'b00_01_0);
    drive(5'd10, 5'd10, 5'd10, 1'b0, 5'd10, 5'd10, 1'b0);
    chk("R9 flags clear", 5'b00_00_0);
    drive(5'd10, 5'd10, 5'd10, 1'b0, 5'd3, 5'd10, 1'b1);
    chk("R9 mem clear", 5'b01_01_0);

    for (int n = 0; n < 3000; n++) begin
      logic [4:0] pool [4];
      logic [4:0] e;
      pool[0] = 5'd0; pool[1] = 5'd1; pool[2] = 5'd2; pool[3] = 5'd31;
      drive(pool[$urandom_range(3)], pool[$urandom_range(3)], pool[$urandom_range(3)],
            1'($urandom_range(1)), pool[$urandom_range(3)], pool[$urandom_range(3)],
            1'($urandom_range(1)));
      e[4:3] = 2'(model_op(int'(ex_src_a)));
      e[2:1] = 2'(model_op(int'(ex_src_b)));
      e[0]   = wb_wr && wb_dst != 0 && wb_dst == mem_store_src;
      chk("R10 random", e);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule